// File: doc/BRIEF.md
# Indexed Colour Palette Loader

This block is a 256-entry colour lookup table with 8 bits each of red, green and blue per entry. Software fills it through a small 32-bit register window that has two live word offsets. One offset selects the entry to be written. The other is a single data register that takes the three colour components one after another. A hidden phase counter tracks which component comes next, and the entry pointer steps forward on its own once a full triple has been written. A whole palette can therefore be loaded with one pointer write followed by a run of data writes.

A scanout engine reads the table through a separate lookup stream. It presents an 8-bit pixel code with a valid strobe, and one clock later it receives the 24-bit colour with its own valid strobe. The lookup stream has no ready signal. The block accepts a request on every cycle, and the consumer must take each result in the cycle it is presented. Register reads return zero, so the table cannot be read back over the bus.

Top module: `pal_dac_top`

## Requirements
- R1: After reset every entry holds zero in all three components, except entry 255, which holds 0xFF/0xFF/0xFF. The entry pointer and the component phase both start at 0, so the first data write goes to the red component of entry 0.
- R2: A full write to byte offset 0 loads the entry pointer from data bits 31:24 and returns the phase to red, even in the middle of a triple.
- R3: A full write to byte offset 4 stores data bits 31:24 into the component of the pointed entry selected by the phase. The phases are red (0), green (1) and blue (2), taken in that order.
- R4: After a blue store the pointer increments modulo 256, so 255 wraps to 0, and the phase returns to red. Red and green stores leave the pointer where it is.
- R5: `bus_rdata` reads as zero at all times.
- R6: Writes to byte offsets 8 and 12 change neither the table, the pointer nor the phase.
- R7: A write whose byte enables are not all set (`bus_be` other than 4'hF) is ignored.
- R8: A write strobe without chip select is ignored.
- R9: A lookup presented with `lk_valid` produces `rgb_valid` on the next cycle, with `rgb_out` = {red[23:16], green[15:8], blue[7:0]} of that entry. `rgb_valid` is low when no lookup was made in the previous cycle.
- R10: If a lookup targets the entry being written in the same cycle, it returns the value from before the write. The new value is visible to a lookup made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register window chip select |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset inside the 16-byte window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data; bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| lk_valid | input | 1 | Lookup request valid |
| lk_index | input | 8 | Pixel code to look up |
| rgb_valid | output | 1 | Lookup result valid, one cycle after the request |
| rgb_out | output | 24 | Looked-up colour {R,G,B} |

## Verification
The bench attacks the hidden sequencing with several targeted cases. It sends a pointer write in the middle of a triple; a design that kept the phase would then store the next byte into green instead of red. It runs a triple at entry 255; a pointer that saturated or took a wider width would miss entry 0 on the following write. It also sends writes with a missing chip select, partial byte enables and the two dead offsets. Each of these is followed by a normal data write, so a sequencer that advanced on any of them shows up as a value in the wrong component. A same-cycle write and lookup of one entry checks that the result carries the old colour, as a write-through design would return the new one early.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int IDXW = 8,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  output logic            wr_en,
  output phase_t          wr_phase,
  output logic [IDXW-1:0] wr_idx,
  output logic [CW-1:0]   wr_val
);
  localparam int          BEW     = DW / 8;
  localparam logic [AW-1:0] OFF_IDX = AW'(0);
  localparam logic [AW-1:0] OFF_DAT = AW'(4);

  logic            acc_ok, sel_idx, sel_dat;
  logic [IDXW-1:0] idx_q;
  phase_t          ph_q;

  assign acc_ok  = cs && we && (be == {BEW{1'b1}});
  assign sel_idx = acc_ok && (addr == OFF_IDX);
  assign sel_dat = acc_ok && (addr == OFF_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (sel_idx) begin
      idx_q <= wdata[DW-1 -: IDXW];
      ph_q  <= PH_RED;
    end else if (sel_dat) begin
      case (ph_q)
        PH_RED:  ph_q <= PH_GRN;
        PH_GRN:  ph_q <= PH_BLU;
        default: begin
          ph_q  <= PH_RED;
          idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign wr_en    = sel_dat;
  assign wr_phase = ph_q;
  assign wr_idx   = idx_q;
  assign wr_val   = wdata[DW-1 -: CW];

  logic unused_low;
  assign unused_low = ^wdata[DW-CW-1:0];

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != phase_t'(2'd3));

  p_blue_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_phase == PH_BLU) |=> (wr_idx == $past(wr_idx) + 1'b1) && (wr_phase == PH_RED));

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && be == {BEW{1'b1}} && addr == OFF_IDX) |=> (wr_phase == PH_RED));

  p_nocs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(wr_idx) && $stable(wr_phase)));

  p_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (be != {BEW{1'b1}}) |=> ($stable(wr_idx) && $stable(wr_phase)));
endmodule

// File: rtl/pal_dac_table.sv
module pal_dac_table
  import pal_dac_pkg::*;
#(
  parameter int IDXW = 8,
  parameter int CW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  phase_t                 wr_phase,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [CW-1:0]          wr_val,
  input  logic                   lk_valid,
  input  logic [IDXW-1:0]        lk_index,
  output logic                   rgb_valid,
  output logic [NUM_COMP*CW-1:0] rgb_out
);
  localparam int ENTRIES = 1 << IDXW;

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_bank
    localparam phase_t MY_PH = phase_t'(g);
    logic [CW-1:0] mem [ENTRIES];
    logic [CW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++)
          mem[e] <= (e == ENTRIES - 1) ? {CW{1'b1}} : {CW{1'b0}};
      end else if (wr_en && wr_phase == MY_PH) begin
        mem[wr_idx] <= wr_val;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        rd_q <= '0;
      else if (lk_valid) rd_q <= mem[lk_index];
    end

    assign rgb_out[(NUM_COMP-1-g)*CW +: CW] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_valid <= 1'b0;
    else        rgb_valid <= lk_valid;
  end

  p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rgb_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rgb_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(rgb_out));
endmodule

// File: rtl/pal_dac_top.sv
module pal_dac_top
  import pal_dac_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int IDXW = 8,
  parameter int CW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_cs,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW/8-1:0]        bus_be,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic                   lk_valid,
  input  logic [IDXW-1:0]        lk_index,
  output logic                   rgb_valid,
  output logic [NUM_COMP*CW-1:0] rgb_out
);
  logic            wr_en;
  phase_t          wr_phase;
  logic [IDXW-1:0] wr_idx;
  logic [CW-1:0]   wr_val;

  assign bus_rdata = '0;

  pal_dac_seq #(.DW(DW), .AW(AW), .IDXW(IDXW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (bus_cs),
    .we       (bus_we),
    .addr     (bus_addr),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .wr_en    (wr_en),
    .wr_phase (wr_phase),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val)
  );

  pal_dac_table #(.IDXW(IDXW), .CW(CW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_phase  (wr_phase),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .lk_valid  (lk_valid),
    .lk_index  (lk_index),
    .rgb_valid (rgb_valid),
    .rgb_out   (rgb_out)
  );
endmodule

// File: tb/pal_dac_top_tb_top.sv
module pal_dac_top_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        bus_cs, bus_we;
  logic [3:0]  bus_addr, bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        lk_valid;
  logic [7:0]  lk_index;
  logic        rgb_valid;
  logic [23:0] rgb_out;

  pal_dac_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_valid(lk_valid), .lk_index(lk_index),
    .rgb_valid(rgb_valid), .rgb_out(rgb_out)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  int m_idx, m_ph;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int e = 0; e < 256; e++) begin
      mr[e] = (e == 255) ? 8'hFF : 8'h00;
      mg[e] = (e == 255) ? 8'hFF : 8'h00;
      mb[e] = (e == 255) ? 8'hFF : 8'h00;
    end
    m_idx = 0;
    m_ph  = 0;
  endfunction

  // one cycle: optional bus write and optional lookup, driven at negedge
  task automatic op(input logic cs, input logic we, input logic [3:0] a, input logic [3:0] be,
                    input logic [31:0] d, input logic lkv, input logic [7:0] lki, input string tag);
    @(negedge clk);
    if (lkv) begin
      exp_q.push_back({mr[lki], mg[lki], mb[lki]});
      tag_q.push_back(tag);
    end
    if (cs && we && be == 4'hF) begin
      if (a == 4'd0) begin
        m_idx = int'(d[31:24]);
        m_ph  = 0;
      end else if (a == 4'd4) begin
        case (m_ph)
          0: begin mr[m_idx] = d[31:24]; m_ph = 1; end
          1: begin mg[m_idx] = d[31:24]; m_ph = 2; end
          default: begin mb[m_idx] = d[31:24]; m_idx = (m_idx + 1) % 256; m_ph = 0; end
        endcase
      end
    end
    bus_cs = cs; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
    lk_valid = lkv; lk_index = lki;
    chk(bus_rdata == 32'h0, "R5 rdata zero", bus_rdata, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    op(1'b1, 1'b1, a, 4'hF, {v, 24'h5A5A5A}, 1'b0, 8'h0, "");
  endtask

  task automatic look(input logic [7:0] i, input string tag);
    op(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, 1'b1, i, tag);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, 1'b0, 8'h0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rgb_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", {8'h0, rgb_out}, 32'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rgb_out == e, t, {8'h0, rgb_out}, {8'h0, e});
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_cs = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    lk_valid = 0; lk_index = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rgb_valid == 1'b0, "R9 reset valid low", {31'h0, rgb_valid}, 32'h0);

    // R1: reset contents
    look(8'd0, "R1 entry0 black");
    look(8'd128, "R1 entry128 black");
    look(8'd255, "R1 entry255 white");
    // R1: pointer/phase at 0 -> first triple lands in entry 0
    wr(4'd4, 8'h11); wr(4'd4, 8'h22); wr(4'd4, 8'h33);
    look(8'd0, "R1 R3 first triple entry0");
    // R4: pointer now 1, red only
    wr(4'd4, 8'h44);
    look(8'd1, "R4 autoinc to entry1");
    // R2: pointer write mid-triple resets phase
    wr(4'd0, 8'd10); wr(4'd4, 8'h55);
    wr(4'd0, 8'd10); wr(4'd4, 8'h77);
    look(8'd10, "R2 phase cleared");
    wr(4'd4, 8'h88); wr(4'd4, 8'h99);
    look(8'd10, "R3 green blue order");
    look(8'd11, "R4 entry11 untouched");
    // R4: wrap 255 -> 0
    wr(4'd0, 8'd255); wr(4'd4, 8'h01); wr(4'd4, 8'h02); wr(4'd4, 8'h03);
    wr(4'd4, 8'hC0);
    look(8'd255, "R4 entry255 written");
    look(8'd0, "R4 wrap to entry0");
    // R6: dead offsets
    wr(4'd0, 8'd20);
    op(1'b1, 1'b1, 4'd8,  4'hF, 32'hE1000000, 1'b0, 8'h0, "");
    op(1'b1, 1'b1, 4'd12, 4'hF, 32'hE2000000, 1'b0, 8'h0, "");
    wr(4'd4, 8'hA1);
    look(8'd20, "R6 dead offsets ignored");
    look(8'hE1, "R6 no pointer load via offset 8");
    // R7: partial byte enables
    op(1'b1, 1'b1, 4'd4, 4'h7, 32'hB1000000, 1'b0, 8'h0, "");
    op(1'b1, 1'b1, 4'd0, 4'hE, 32'h30000000, 1'b0, 8'h0, "");
    wr(4'd4, 8'hA2);
    look(8'd20, "R7 partial writes ignored");
    // R8: no chip select
    op(1'b0, 1'b1, 4'd4, 4'hF, 32'hB2000000, 1'b0, 8'h0, "");
    op(1'b0, 1'b1, 4'd0, 4'hF, 32'h40000000, 1'b0, 8'h0, "");
    wr(4'd4, 8'hA3);
    look(8'd20, "R8 no-cs writes ignored");
    look(8'd21, "R8 pointer advanced to 21");
    // R10: collision, write red of entry 21 while looking it up
    op(1'b1, 1'b1, 4'd4, 4'hF, 32'hD5000000, 1'b1, 8'd21, "R10 old value on collision");
    look(8'd21, "R10 new value next cycle");
    // R3/R9: sweep with back-to-back lookups
    wr(4'd0, 8'd64);
    for (int k = 0; k < 16; k++) begin
      wr(4'd4, 8'(k * 3 + 1)); wr(4'd4, 8'(k * 5 + 2)); wr(4'd4, 8'(255 - k * 7));
    end
    for (int k = 0; k < 16; k++) look(8'(64 + k), "R3 R9 sweep");
    look(8'd80, "R4 sweep end untouched");
    idle(); idle(); idle();
    chk(exp_q.size() == 0, "R9 all lookups answered", exp_q.size(), 32'h0);
    chk(rgb_valid == 1'b0, "R9 valid low when idle", {31'h0, rgb_valid}, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule